// File: doc/BRIEF.md
# Frame Status Queue with Indexed Register Readback

This block belongs to the receive side of a serial communications controller. Each time the receiver closes a frame, it hands over a 14-bit byte count. The block keeps these counts in a small first-in first-out store. A 4-bit indexed read port lets software fetch them, together with an overflow flag and a data-available flag.

The same read port also serves several other locations. Some show a write-register copy or a status register, depending on two control bits. When the queue is switched off, its two locations fall back to images of lower status registers. Indices 8 to 15 are not decoded here. The port returns zero for them so that the surrounding map can merge its own data.

Software reads one frame in a fixed order: the high location (7), then the low location (6), then status register 1 (index 1). The strobed read of index 1 retires the head entry.

Top module: `frame_stat_fifo`

## Requirements
- R1: Indices 0, 1, 2 and 3 return the inputs stat0, stat1, stat2 and stat3. Indices 8 to 15 return 0x00.
- R2: Index 4 returns wcopy4 when ext_rd is 1, and stat0 when ext_rd is 0.
- R3: Index 5 returns wcopy5 when ext_rd is 1, and stat1 when ext_rd is 0.
- R4: Index 6 returns bits 7:0 of the head byte count when fifo_en is 1, or 0x00 if the queue is empty. It returns stat2 when fifo_en is 0.
- R5: When fifo_en is 1, index 7 returns overflow in bit 7, data available (queue not empty) in bit 6, and bits 13:8 of the head count in bits 5:0. The count bits read 0 when the queue is empty. When fifo_en is 0, index 7 returns stat3.
- R6: While fifo_en is 1, a cycle with push_valid high appends push_count, and entries leave in arrival order. The queue holds ten entries.
- R7: A cycle with rd_strobe high, rd_index equal to 1, fifo_en high and a non-empty queue removes the head entry. Strobed reads of any other index, including 5, 6 and 7, leave the queue unchanged.
- R8: A push into a full queue with no pop in the same cycle is dropped and sets the overflow flag. The flag then stays set.
- R9: A push and a pop in the same cycle are both carried out and occupancy is unchanged, including when the queue is full.
- R10: While fifo_en is 0, pushes are ignored, the queue is emptied and the overflow flag is cleared.
- R11: A synchronous active-high reset empties the queue and clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | End of frame: store push_count |
| push_count | input | 14 | Byte count of the closed frame |
| rd_strobe | input | 1 | Read access in this cycle |
| rd_index | input | 4 | Read location |
| rd_data | output | 8 | Read data, combinational from rd_index |
| stat0 | input | 8 | Status register 0 value |
| stat1 | input | 8 | Status register 1 value |
| stat2 | input | 8 | Status register 2 value |
| stat3 | input | 8 | Status register 3 value |
| wcopy4 | input | 8 | Copy of write register 4 |
| wcopy5 | input | 8 | Copy of write register 5 |
| fifo_en | input | 1 | Queue enable (bit 2 of write register 15) |
| ext_rd | input | 1 | Extended read: mirror write registers at 4 and 5 |

## Verification
Two operations can fall on the same clock edge: a push of a new frame count and the pop caused by a strobed read of index 1. The bench sets up these collisions with the queue partly filled, full, and empty. When full, the pop must make room so the push is kept without overflow. When empty, only the push takes effect. After each collision the bench walks the queue with reads of locations 7 and 6 and compares occupancy, order and the overflow bit against an arithmetic model.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
    localparam logic [3:0] IDX_MIR4  = 4'd4;
    localparam logic [3:0] IDX_MIR5  = 4'd5;
    localparam logic [3:0] IDX_CNTLO = 4'd6;
    localparam logic [3:0] IDX_CNTHI = 4'd7;
    localparam logic [3:0] IDX_POP   = 4'd1;

    typedef enum logic [3:0] {
        SEL_ZERO,
        SEL_S0,
        SEL_S1,
        SEL_S2,
        SEL_S3,
        SEL_W4,
        SEL_W5,
        SEL_LO,
        SEL_HI
    } rd_sel_e;
endpackage

// File: rtl/fsf_ctrl.sv
module fsf_ctrl #(
    parameter int DEPTH = 10,
    parameter int PW    = 4,
    parameter int LW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          push,
    input  logic          pop_req,
    output logic          wr_en,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [LW-1:0] level,
    output logic          ovf
);
    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [LW-1:0] lvl;
        logic          ovf;
    } ctrl_t;

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    ctrl_t st_q, st_d;
    logic  pop_ok, push_ok, is_full, is_empty;

    always_comb begin
        st_d     = st_q;
        is_full  = (st_q.lvl == FULL);
        is_empty = (st_q.lvl == '0);
        pop_ok   = fifo_en && pop_req && !is_empty;
        push_ok  = fifo_en && push && (!is_full || pop_ok);
        if (!fifo_en) begin
            st_d = '0;
        end else begin
            if (pop_ok) begin
                st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
            end
            if (push_ok) begin
                st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                st_d.lvl = st_q.lvl + 1'b1;
            end else if (pop_ok && !push_ok) begin
                st_d.lvl = st_q.lvl - 1'b1;
            end
            if (push && !push_ok) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en  = push_ok;
    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign level  = st_q.lvl;
    assign ovf    = st_q.ovf;
endmodule

// File: rtl/fsf_store.sv
module fsf_store #(
    parameter int DEPTH = 10,
    parameter int CW    = 14,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  logic [CW-1:0] wr_data,
    input  logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] head
);
    logic [CW-1:0] mem_q [DEPTH];
    logic [CW-1:0] mem_d [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_comb begin
                mem_d[g] = mem_q[g];
                if (wr_en && (wr_ptr == PW'(g))) begin
                    mem_d[g] = wr_data;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    mem_q[g] <= '0;
                end else begin
                    mem_q[g] <= mem_d[g];
                end
            end
        end
    endgenerate

    always_comb begin
        head = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_ptr == PW'(i)) begin
                head = mem_q[i];
            end
        end
    end
endmodule

// File: rtl/fsf_rdmux.sv
module fsf_rdmux #(
    parameter int CW = 14
) (
    input  logic [3:0]    rd_index,
    input  logic          fifo_en,
    input  logic          ext_rd,
    input  logic [7:0]    stat0,
    input  logic [7:0]    stat1,
    input  logic [7:0]    stat2,
    input  logic [7:0]    stat3,
    input  logic [7:0]    wcopy4,
    input  logic [7:0]    wcopy5,
    input  logic [CW-1:0] head,
    input  logic          avail,
    input  logic          ovf,
    output logic [7:0]    rd_data
);
    import fsf_pkg::*;

    localparam int HW = CW - 8;

    rd_sel_e    sel;
    logic [CW-1:0] cnt;
    logic [5:0]    hi_bits;

    always_comb begin
        unique case (rd_index)
            4'd0:      sel = SEL_S0;
            4'd1:      sel = SEL_S1;
            4'd2:      sel = SEL_S2;
            4'd3:      sel = SEL_S3;
            IDX_MIR4:  sel = ext_rd  ? SEL_W4 : SEL_S0;
            IDX_MIR5:  sel = ext_rd  ? SEL_W5 : SEL_S1;
            IDX_CNTLO: sel = fifo_en ? SEL_LO : SEL_S2;
            IDX_CNTHI: sel = fifo_en ? SEL_HI : SEL_S3;
            default:   sel = SEL_ZERO;
        endcase
    end

    always_comb begin
        cnt     = avail ? head : '0;
        hi_bits = 6'(cnt[CW-1:8]);
        unique case (sel)
            SEL_S0:  rd_data = stat0;
            SEL_S1:  rd_data = stat1;
            SEL_S2:  rd_data = stat2;
            SEL_S3:  rd_data = stat3;
            SEL_W4:  rd_data = wcopy4;
            SEL_W5:  rd_data = wcopy5;
            SEL_LO:  rd_data = cnt[7:0];
            SEL_HI:  rd_data = {ovf, avail, hi_bits};
            default: rd_data = 8'h00;
        endcase
    end

    if (HW > 6) begin : g_width_note
        // count bits above 13 are not reachable through location 7
    end
endmodule

// File: rtl/frame_stat_fifo.sv
module frame_stat_fifo #(
    parameter int DEPTH = 10,
    parameter int CW    = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_valid,
    input  logic [CW-1:0] push_count,
    input  logic          rd_strobe,
    input  logic [3:0]    rd_index,
    output logic [7:0]    rd_data,
    input  logic [7:0]    stat0,
    input  logic [7:0]    stat1,
    input  logic [7:0]    stat2,
    input  logic [7:0]    stat3,
    input  logic [7:0]    wcopy4,
    input  logic [7:0]    wcopy5,
    input  logic          fifo_en,
    input  logic          ext_rd
);
    import fsf_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic          pop_req;
    logic          wr_en;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] lvl;
    logic          ovf;
    logic [CW-1:0] head;

    assign pop_req = rd_strobe && (rd_index == IDX_POP);

    fsf_ctrl #(.DEPTH(DEPTH), .PW(PW), .LW(LW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .fifo_en (fifo_en),
        .push    (push_valid),
        .pop_req (pop_req),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .level   (lvl),
        .ovf     (ovf)
    );

    fsf_store #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (push_count),
        .rd_ptr  (rd_ptr),
        .head    (head)
    );

    fsf_rdmux #(.CW(CW)) u_mux (
        .rd_index (rd_index),
        .fifo_en  (fifo_en),
        .ext_rd   (ext_rd),
        .stat0    (stat0),
        .stat1    (stat1),
        .stat2    (stat2),
        .stat3    (stat3),
        .wcopy4   (wcopy4),
        .wcopy5   (wcopy5),
        .head     (head),
        .avail    (lvl != '0),
        .ovf      (ovf),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/fsf_checker.sv
module fsf_checker #(
    parameter int DEPTH = 10,
    parameter int LW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_en,
    input logic          ext_rd,
    input logic          push_valid,
    input logic          rd_strobe,
    input logic [3:0]    rd_index,
    input logic [7:0]    rd_data,
    input logic [7:0]    wcopy4,
    input logic [LW-1:0] lvl,
    input logic          ovf
);
    logic pop_now;
    assign pop_now = rd_strobe && (rd_index == 4'd1) && fifo_en && (lvl != '0);

    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lvl <= LW'(DEPTH));

    // R8
    full_push_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && push_valid && lvl == LW'(DEPTH) && !pop_now) |=> ovf);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && ovf) |=> ovf);

    // R10
    disabled_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> (!ovf && lvl == '0));

    // R9
    swap_level_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_now && push_valid) |=> (lvl == $past(lvl)));

    // R7
    no_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && !push_valid && !(rd_strobe && rd_index == 4'd1)) |=> (lvl == $past(lvl) || lvl == '0));

    // R2
    mirror4_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_index == 4'd4 && ext_rd) |-> (rd_data == wcopy4));

    // R4
    empty_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_index == 4'd6 && fifo_en && lvl == '0) |-> (rd_data == 8'h00));
endmodule

bind frame_stat_fifo fsf_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .ext_rd     (ext_rd),
    .push_valid (push_valid),
    .rd_strobe  (rd_strobe),
    .rd_index   (rd_index),
    .rd_data    (rd_data),
    .wcopy4     (wcopy4),
    .lvl        (lvl),
    .ovf        (ovf)
);

// File: tb/frame_stat_fifo_test.sv
`timescale 1ns/1ps
module frame_stat_fifo_test;
    localparam int D = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        push_valid;
    logic [13:0] push_count;
    logic        rd_strobe;
    logic [3:0]  rd_index;
    logic [7:0]  rd_data;
    logic [7:0]  stat0, stat1, stat2, stat3, wcopy4, wcopy5;
    logic        fifo_en, ext_rd;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int mq[$];
    bit movf;

    always #2.5 clk = ~clk;

    frame_stat_fifo uut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_count(push_count),
        .rd_strobe(rd_strobe), .rd_index(rd_index), .rd_data(rd_data),
        .stat0(stat0), .stat1(stat1), .stat2(stat2), .stat3(stat3),
        .wcopy4(wcopy4), .wcopy5(wcopy5), .fifo_en(fifo_en), .ext_rd(ext_rd)
    );

    function automatic logic [7:0] expect_rd(input logic [3:0] idx);
        logic [13:0] h;
        h = (mq.size() > 0) ? 14'(mq[0]) : 14'd0;
        case (idx)
            4'd0: return stat0;
            4'd1: return stat1;
            4'd2: return stat2;
            4'd3: return stat3;
            4'd4: return ext_rd ? wcopy4 : stat0;
            4'd5: return ext_rd ? wcopy5 : stat1;
            4'd6: return fifo_en ? h[7:0] : stat2;
            4'd7: return fifo_en ? {movf, mq.size() > 0, h[13:8]} : stat3;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s idx=%0d actual=%02h expected=%02h", req, rd_index, act, exp);
        end
    endtask

    // read a location combinationally (no strobe) and compare
    task automatic peek(input string req, input logic [3:0] idx);
        @(negedge clk);
        rd_strobe = 1'b0;
        push_valid = 1'b0;
        rd_index = idx;
        #1;
        check(req, rd_data, expect_rd(idx));
    endtask

    // one clock with the given stimulus, model updated at the edge
    task automatic cycle(input bit psh, input int cnt, input bit stb, input logic [3:0] idx);
        bit pop, ok;
        @(negedge clk);
        push_valid = psh;
        push_count = 14'(cnt);
        rd_strobe  = stb;
        rd_index   = idx;
        @(posedge clk);
        if (!fifo_en) begin
            mq.delete();
            movf = 0;
        end else begin
            pop = stb && idx == 4'd1 && mq.size() > 0;
            ok  = psh && (mq.size() < D || pop);
            if (pop) void'(mq.pop_front());
            if (ok) mq.push_back(cnt);
            else if (psh) movf = 1;
        end
    endtask

    task automatic read_frame(input string req);
        peek(req, 4'd7);
        peek(req, 4'd6);
        cycle(0, 0, 1, 4'd7);
        cycle(0, 0, 1, 4'd6);
        peek("R7", 4'd7);
        cycle(0, 0, 1, 4'd1);
        peek(req, 4'd7);
        peek(req, 4'd6);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; push_valid = 0; push_count = 0; rd_strobe = 0; rd_index = 0;
        stat0 = 8'h10; stat1 = 8'h21; stat2 = 8'h32; stat3 = 8'h43;
        wcopy4 = 8'hA4; wcopy5 = 8'hB5; fifo_en = 1'b1; ext_rd = 1'b0;
        movf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R11 reset state: empty, no overflow
        peek("R11", 4'd7);
        peek("R11", 4'd6);

        // R1..R5 static sweep over every index and both control bits
        for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 4; m++) begin
                @(negedge clk);
                stat0 = 8'(8'h13 * k + 1); stat1 = 8'(8'h29 * k + 2);
                stat2 = 8'(8'h3B * k + 3); stat3 = 8'(8'h57 * k + 4);
                wcopy4 = 8'(8'h61 * k + 5); wcopy5 = 8'(8'h7F * k + 6);
                fifo_en = m[0]; ext_rd = m[1];
                @(posedge clk);
                if (!fifo_en) begin mq.delete(); movf = 0; end
                for (int i = 0; i < 16; i++) begin
                    case (i)
                        0, 1, 2, 3: peek("R1", 4'(i));
                        4: peek("R2", 4'(i));
                        5: peek("R3", 4'(i));
                        6: peek("R4", 4'(i));
                        7: peek("R5", 4'(i));
                        default: peek("R1", 4'(i));
                    endcase
                end
            end
        end

        // R6 fill, R8 overflow on the two extra pushes
        @(negedge clk); fifo_en = 1'b1; ext_rd = 1'b0;
        for (int n = 0; n < 12; n++) begin
            cycle(1, 700 + 1337 * n, 0, 4'd0);
            peek(n < D ? "R6" : "R8", 4'd7);
            peek("R6", 4'd6);
        end
        // R7 strobed reads of non-pop indices leave queue
        for (int i = 0; i < 16; i++) begin
            if (i != 1) cycle(0, 0, 1, 4'(i));
        end
        peek("R7", 4'd7);
        peek("R7", 4'd6);
        // R9 push and pop together while full
        cycle(1, 16383, 1, 4'd1);
        peek("R9", 4'd7);
        peek("R9", 4'd6);
        // drain in the intended order, checking order and sticky overflow
        for (int n = 0; n < 4; n++) read_frame("R6");
        // R9 collision while partly filled
        cycle(1, 8191, 1, 4'd1);
        peek("R9", 4'd7);
        for (int n = 0; n < 7; n++) read_frame("R8");
        // R9 collision on empty: only the push happens
        cycle(1, 300, 1, 4'd1);
        peek("R9", 4'd7);
        peek("R9", 4'd6);
        // extra pop on one entry then on empty
        cycle(0, 0, 1, 4'd1);
        cycle(0, 0, 1, 4'd1);
        peek("R7", 4'd7);

        // R10 disable clears overflow and contents; pushes ignored
        cycle(1, 55, 0, 4'd0);
        @(negedge clk) fifo_en = 1'b0;
        cycle(1, 77, 0, 4'd0);
        cycle(1, 99, 0, 4'd0);
        peek("R10", 4'd7);
        peek("R10", 4'd6);
        @(negedge clk) fifo_en = 1'b1;
        peek("R10", 4'd7);
        peek("R10", 4'd6);

        // R11 reset with entries and overflow pending
        for (int n = 0; n < 11; n++) cycle(1, 4000 + n, 0, 4'd0);
        peek("R8", 4'd7);
        @(negedge clk) rst = 1'b1;
        @(posedge clk); mq.delete(); movf = 0;
        @(negedge clk) rst = 1'b0;
        peek("R11", 4'd7);
        peek("R11", 4'd6);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule